// File: doc/BRIEF.md
# Joined Boundary and Core Scan Path Selector

This block sits next to a test access port controller and steers its data-register path for one private instruction. While that instruction is held in the instruction register, the boundary-scan register and the internal core scan chain are linked into one serial path between the test data input and the test data output. A full internal test pattern is then applied by shifting through both chains at once, passing through Capture-DR once, and shifting again. The instruction is never reloaded between patterns.

The block takes the controller's Shift-DR and Capture-DR decodes, the current instruction, the test data input, and the serial outputs of both chains. It returns the serial input for each chain, the boundary shift and capture enables, the core scan-enable, and a core clock enable. It also returns a test data output that is retimed on the falling test clock edge. A build-time parameter chooses which chain comes first in the path. With N core cells and B boundary cells, one pattern takes N+B+4 test clock cycles: N+B to shift, three to walk the controller to Capture-DR, and one to capture. The serial path is a bit stream paced only by the test clock, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or data pin.

Top module: `scan_path_joiner`

## Requirements
- R1: When the instruction input differs from the OPCODE parameter, both chain serial inputs equal the test data input and all four enables are 0, whatever the state decodes are.
- R2: With ORDER = 0 (boundary first) and the instruction selected, the boundary serial input is the test data input, the core serial input is the boundary serial output, and the path tail is the core serial output.
- R3: With ORDER = 1 (core first) and the instruction selected, the core serial input is the test data input, the boundary serial input is the core serial output, and the path tail is the boundary serial output.
- R4: With the instruction selected and Shift-DR high, the boundary shift enable, the core scan-enable and the core clock enable are all 1, and the boundary capture enable is 0.
- R5: With the instruction selected and Capture-DR high, the boundary capture enable and the core clock enable are 1, and the core scan-enable is 0, so that the core cells capture through their functional paths on the edge that leaves Capture-DR.
- R6: With the instruction selected and neither decode high, all four enables are 0. At most one of the two decodes is ever high.
- R7: On each falling test clock edge, the output enable takes the value (selected AND Shift-DR). When that value is 1, the test data output loads the path tail. Otherwise the test data output holds its value.
- R8: While the active-low test reset is asserted, the test data output and its output enable are 0.
- R9: Back-to-back patterns with no instruction reload unload, bit for bit, the previous pattern's captured response. Boundary cells return the captured pin values and core cells return their functional next state, in path order from the tail. The new pattern loads during those same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low test reset |
| ir | input | IR_W | Current instruction register contents |
| st_shift_dr | input | 1 | Controller is in Shift-DR |
| st_capture_dr | input | 1 | Controller is in Capture-DR |
| tdi | input | 1 | Test data input |
| bsr_so | input | 1 | Boundary-scan register serial output |
| core_so | input | 1 | Internal scan chain serial output |
| bsr_si | output | 1 | Boundary-scan register serial input |
| core_si | output | 1 | Internal scan chain serial input |
| bsr_shift_en | output | 1 | Boundary register shift enable |
| bsr_capture_en | output | 1 | Boundary register parallel capture enable |
| core_scan_en | output | 1 | Core scan-enable (shift vs functional capture) |
| core_clk_en | output | 1 | Core clock enable (test clock used as system clock) |
| tdo | output | 1 | Retimed test data output |
| tdo_oe | output | 1 | Test data output drive enable |

## Verification
Two functions coincide on every shift cycle of a pattern after the first. The response captured by the previous pattern leaves through the test data output while the new stimulus enters at the test data input. The bench provokes this with behavioural boundary and core chains around two instances, one per ordering. It runs three patterns back to back with one capture cycle between them and no instruction change. Each unloaded bit is compared with a value computed arithmetically from the previous stimulus, with core bits inverted as their functional response and boundary bits replaced by fixed pin values. The next pattern's unload then confirms that the stimulus loaded in parallel arrived intact. An exhaustive sweep over instruction, state and serial inputs covers the routing, enables and output retiming.

// File: rtl/scan_join_pkg.sv
`timescale 1ns/1ps
package scan_join_pkg;
  typedef enum logic {
    ORDER_BSR_FIRST  = 1'b0,
    ORDER_CORE_FIRST = 1'b1
  } chain_order_e;
endpackage

// File: rtl/join_instr_decode.sv
`timescale 1ns/1ps
module join_instr_decode #(
  parameter int unsigned IR_W = 4,
  parameter logic [IR_W-1:0] OPCODE = 4'hA
) (
  input  logic [IR_W-1:0] ir,
  input  logic            st_shift_dr,
  input  logic            st_capture_dr,
  output logic            sel,
  output logic            shift_go,
  output logic            capture_go
);
  always_comb begin
    sel        = (ir == OPCODE);
    shift_go   = sel & st_shift_dr;
    capture_go = sel & st_capture_dr;
  end
endmodule

// File: rtl/join_serial_router.sv
`timescale 1ns/1ps
module join_serial_router #(
  parameter scan_join_pkg::chain_order_e ORDER = scan_join_pkg::ORDER_BSR_FIRST
) (
  input  logic tck,
  input  logic trst_n,
  input  logic sel,
  input  logic tdi,
  input  logic bsr_so,
  input  logic core_so,
  output logic bsr_si,
  output logic core_si,
  output logic tail_so
);
  generate
    if (ORDER == scan_join_pkg::ORDER_BSR_FIRST) begin : g_bsr_first
      always_comb begin
        bsr_si  = tdi;
        core_si = sel ? bsr_so : tdi;
        tail_so = core_so;
      end
      AST_BSR_FEEDS_CORE: assert property (@(posedge tck) disable iff (!trst_n)
        sel |-> (core_si == bsr_so)); // R2
    end else begin : g_core_first
      always_comb begin
        core_si = tdi;
        bsr_si  = sel ? core_so : tdi;
        tail_so = bsr_so;
      end
      AST_CORE_FEEDS_BSR: assert property (@(posedge tck) disable iff (!trst_n)
        sel |-> (bsr_si == core_so)); // R3
    end
  endgenerate
endmodule

// File: rtl/join_enable_gen.sv
`timescale 1ns/1ps
module join_enable_gen (
  input  logic shift_go,
  input  logic capture_go,
  output logic bsr_shift_en,
  output logic bsr_capture_en,
  output logic core_scan_en,
  output logic core_clk_en
);
  always_comb begin
    bsr_shift_en   = shift_go;
    bsr_capture_en = capture_go & ~shift_go;
    core_scan_en   = shift_go;
    core_clk_en    = shift_go | capture_go;
  end
endmodule

// File: rtl/join_tdo_retimer.sv
`timescale 1ns/1ps
module join_tdo_retimer (
  input  logic tck,
  input  logic trst_n,
  input  logic shift_go,
  input  logic tail_so,
  output logic tdo,
  output logic tdo_oe
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= shift_go;
      if (shift_go) tdo <= tail_so;
    end
  end

  AST_TDO_HOLDS: assert property (@(negedge tck) disable iff (!trst_n)
    !shift_go |=> $stable(tdo)); // R7
endmodule

// File: rtl/scan_path_joiner.sv
`timescale 1ns/1ps
module scan_path_joiner #(
  parameter int unsigned IR_W = 4,
  parameter logic [IR_W-1:0] OPCODE = 4'hA,
  parameter scan_join_pkg::chain_order_e ORDER = scan_join_pkg::ORDER_BSR_FIRST
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic [IR_W-1:0] ir,
  input  logic            st_shift_dr,
  input  logic            st_capture_dr,
  input  logic            tdi,
  input  logic            bsr_so,
  input  logic            core_so,
  output logic            bsr_si,
  output logic            core_si,
  output logic            bsr_shift_en,
  output logic            bsr_capture_en,
  output logic            core_scan_en,
  output logic            core_clk_en,
  output logic            tdo,
  output logic            tdo_oe
);
  logic sel, shift_go, capture_go, tail_so;

  join_instr_decode #(.IR_W(IR_W), .OPCODE(OPCODE)) u_dec (
    .ir(ir), .st_shift_dr(st_shift_dr), .st_capture_dr(st_capture_dr),
    .sel(sel), .shift_go(shift_go), .capture_go(capture_go));

  join_serial_router #(.ORDER(ORDER)) u_route (
    .tck(tck), .trst_n(trst_n), .sel(sel), .tdi(tdi),
    .bsr_so(bsr_so), .core_so(core_so),
    .bsr_si(bsr_si), .core_si(core_si), .tail_so(tail_so));

  join_enable_gen u_en (
    .shift_go(shift_go), .capture_go(capture_go),
    .bsr_shift_en(bsr_shift_en), .bsr_capture_en(bsr_capture_en),
    .core_scan_en(core_scan_en), .core_clk_en(core_clk_en));

  join_tdo_retimer u_tdo (
    .tck(tck), .trst_n(trst_n), .shift_go(shift_go), .tail_so(tail_so),
    .tdo(tdo), .tdo_oe(tdo_oe));

  AST_UNSELECTED_PASSTHRU: assert property (@(posedge tck) disable iff (!trst_n)
    (ir != OPCODE) |-> (bsr_si == tdi && core_si == tdi && !core_clk_en && !bsr_shift_en)); // R1
  AST_SCAN_CLOCKED: assert property (@(posedge tck) disable iff (!trst_n)
    core_scan_en |-> (core_clk_en && bsr_shift_en && !bsr_capture_en)); // R4
  AST_CAPTURE_FUNCTIONAL: assert property (@(posedge tck) disable iff (!trst_n)
    (core_clk_en && !core_scan_en) |-> bsr_capture_en); // R5
  AST_ONE_DR_STATE: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({st_shift_dr, st_capture_dr})); // R6
endmodule

// File: tb/sim_scan_path_joiner.sv
`timescale 1ns/1ps
module chain_model #(parameter int L = 2) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         cap_en,
  input  logic         si,
  input  logic [L-1:0] cap_val,
  output logic [L-1:0] q,
  output logic         so
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (shift_en) q <= {q[L-2:0], si};
    else if (cap_en) q <= cap_val;
  end
  assign so = q[L-1];
endmodule

module sim_scan_path_joiner;
  localparam int NC = 3;
  localparam int NB = 2;
  localparam int T  = NC + NB;
  localparam logic [NB-1:0] PINS = 2'b10;
  localparam logic [3:0] OPC0 = 4'hA;
  localparam logic [3:0] OPC1 = 4'h5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic trst_n = 1'b0;
  logic [3:0] ir0 = '0, ir1 = '0;
  logic sh = 0, cp = 0, tdi_r = 0, force_m = 1, fb = 0, fc = 0;
  int n_chk = 0, n_err = 0;

  logic b0_si, c0_si, b0_sh, b0_cp, c0_se, c0_ce, tdo0, oe0;
  logic b1_si, c1_si, b1_sh, b1_cp, c1_se, c1_ce, tdo1, oe1;
  logic [NB-1:0] bq0, bq1;
  logic [NC-1:0] cq0, cq1;
  logic bso0, cso0, bso1, cso1;

  scan_path_joiner #(.IR_W(4), .OPCODE(OPC0), .ORDER(scan_join_pkg::ORDER_BSR_FIRST)) u0 (
    .tck(clk), .trst_n(trst_n), .ir(ir0), .st_shift_dr(sh), .st_capture_dr(cp),
    .tdi(tdi_r), .bsr_so(force_m ? fb : bso0), .core_so(force_m ? fc : cso0),
    .bsr_si(b0_si), .core_si(c0_si), .bsr_shift_en(b0_sh), .bsr_capture_en(b0_cp),
    .core_scan_en(c0_se), .core_clk_en(c0_ce), .tdo(tdo0), .tdo_oe(oe0));

  scan_path_joiner #(.IR_W(4), .OPCODE(OPC1), .ORDER(scan_join_pkg::ORDER_CORE_FIRST)) u1 (
    .tck(clk), .trst_n(trst_n), .ir(ir1), .st_shift_dr(sh), .st_capture_dr(cp),
    .tdi(tdi_r), .bsr_so(force_m ? fb : bso1), .core_so(force_m ? fc : cso1),
    .bsr_si(b1_si), .core_si(c1_si), .bsr_shift_en(b1_sh), .bsr_capture_en(b1_cp),
    .core_scan_en(c1_se), .core_clk_en(c1_ce), .tdo(tdo1), .tdo_oe(oe1));

  chain_model #(.L(NB)) m_b0 (.clk(clk), .rst_n(trst_n), .shift_en(b0_sh), .cap_en(b0_cp),
    .si(b0_si), .cap_val(PINS), .q(bq0), .so(bso0));
  chain_model #(.L(NC)) m_c0 (.clk(clk), .rst_n(trst_n), .shift_en(c0_ce & c0_se),
    .cap_en(c0_ce & ~c0_se), .si(c0_si), .cap_val(~cq0), .q(cq0), .so(cso0));
  chain_model #(.L(NB)) m_b1 (.clk(clk), .rst_n(trst_n), .shift_en(b1_sh), .cap_en(b1_cp),
    .si(b1_si), .cap_val(PINS), .q(bq1), .so(bso1));
  chain_model #(.L(NC)) m_c1 (.clk(clk), .rst_n(trst_n), .shift_en(c1_ce & c1_se),
    .cap_en(c1_ce & ~c1_se), .si(c1_si), .cap_val(~cq1), .q(cq1), .so(cso1));

  task automatic chk(input string rq, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b at %0t", rq, act, exp, $time);
    end
  endtask

  // Expected unload bit j of a pattern whose stimulus was d (bit 0 shifted first).
  function automatic logic unload_bit(input logic core_first, input logic [T-1:0] d, input int j);
    int k;
    k = T - 1 - j;
    if (!core_first) return (k < NB) ? PINS[k] : ~d[j];
    else             return (k < NC) ? ~d[j] : PINS[k-NC];
  endfunction

  task automatic step(input logic s, input logic c, input logic t);
    @(posedge clk); #1;
    sh = s; cp = c; tdi_r = t;
  endtask

  task automatic run_pattern(input logic [T-1:0] d, input logic chk_prev, input logic [T-1:0] pd);
    for (int j = 0; j < T; j++) begin
      step(1'b1, 1'b0, d[j]);
      #2.5;
      chk("R7 oe in shift u0", oe0, 1'b1);
      if (chk_prev) begin
        chk("R9 R2 unload u0", tdo0, unload_bit(1'b0, pd, j));
        chk("R9 R3 unload u1", tdo1, unload_bit(1'b1, pd, j));
      end
    end
    for (int j = 0; j < 3; j++) begin
      step(1'b0, 1'b0, 1'b0);
      #0.5;
      chk("R6 transit clk_en u0", c0_ce, 1'b0);
      chk("R6 transit clk_en u1", c1_ce, 1'b0);
    end
    step(1'b0, 1'b1, 1'b0);
    #0.5;
    chk("R5 capture scan_en u0", c0_se, 1'b0);
    chk("R5 capture clk_en u1", c1_ce, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic e_tdo0, e_tdo1;
    e_tdo0 = 0; e_tdo1 = 0;
    repeat (3) @(posedge clk);
    #3.5;
    chk("R8 reset tdo u0", tdo0, 1'b0);
    chk("R8 reset oe u0", oe0, 1'b0);
    chk("R8 reset tdo u1", tdo1, 1'b0);
    chk("R8 reset oe u1", oe1, 1'b0);
    @(posedge clk); #1; trst_n = 1'b1;

    // Exhaustive sweep: instruction x DR state x serial inputs
    for (int irv = 0; irv < 16; irv++) begin
      for (int st = 0; st < 3; st++) begin
        for (int v = 0; v < 8; v++) begin
          logic s0, s1, s, c;
          @(posedge clk); #1;
          ir0 = irv[3:0]; ir1 = irv[3:0];
          s = (st == 1); c = (st == 2);
          sh = s; cp = c;
          tdi_r = v[0]; fb = v[1]; fc = v[2];
          s0 = (irv[3:0] == OPC0); s1 = (irv[3:0] == OPC1);
          #0.5;
          // u0: boundary first
          chk(s0 ? "R2 bsr_si u0" : "R1 bsr_si u0", b0_si, tdi_r);
          chk(s0 ? "R2 core_si u0" : "R1 core_si u0", c0_si, s0 ? fb : tdi_r);
          chk("R4 R6 R1 bsr_sh u0", b0_sh, s0 & s);
          chk("R5 R6 R1 bsr_cp u0", b0_cp, s0 & c);
          chk("R4 R5 R1 scan_en u0", c0_se, s0 & s);
          chk("R4 R5 R1 clk_en u0", c0_ce, s0 & (s | c));
          // u1: core first
          chk(s1 ? "R3 core_si u1" : "R1 core_si u1", c1_si, tdi_r);
          chk(s1 ? "R3 bsr_si u1" : "R1 bsr_si u1", b1_si, s1 ? fc : tdi_r);
          chk("R4 R6 R1 bsr_sh u1", b1_sh, s1 & s);
          chk("R5 R6 R1 bsr_cp u1", b1_cp, s1 & c);
          chk("R4 R5 R1 scan_en u1", c1_se, s1 & s);
          chk("R4 R5 R1 clk_en u1", c1_ce, s1 & (s | c));
          if (s0 & s) e_tdo0 = fc;
          if (s1 & s) e_tdo1 = fb;
          #2;
          chk("R7 R2 tdo u0", tdo0, e_tdo0);
          chk("R7 oe u0", oe0, s0 & s);
          chk("R7 R3 tdo u1", tdo1, e_tdo1);
          chk("R7 oe u1", oe1, s1 & s);
        end
      end
    end

    // Back-to-back patterns through modelled chains, instruction never reloaded
    step(1'b0, 1'b0, 1'b0);
    force_m = 1'b0; ir0 = OPC0; ir1 = OPC1;
    run_pattern(5'b10110, 1'b0, 5'b0);
    run_pattern(5'b01101, 1'b1, 5'b10110);
    run_pattern(5'b00000, 1'b1, 5'b01101);
    step(1'b0, 1'b0, 1'b0);
    #3.5;
    chk("R7 oe after shift u0", oe0, 1'b0);
    chk("R7 oe after shift u1", oe1, 1'b0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule